// File: doc/BRIEF.md
# Graph Traversal Region Classifier

This block sits beside a data cache and watches two streams of traffic: demand loads issued by the core and fill data returning from prefetches issued earlier. Software describes a breadth-first graph traversal by programming four address windows (the pending-vertex queue, the per-vertex edge-offset array, the edge-target array and the seen-flag array). Every snooped event whose virtual address falls inside one of those windows becomes a tagged record. The record names the window, the element number inside it, whether the event came from the core or from a fill, and the 64-bit data word that was seen.

Events whose address falls outside every window are thrown away, so a downstream prefetch engine only reacts to traversal traffic. The record is held in a single output register with a valid/ready handshake. Snooped traffic cannot be stalled, so an event that arrives while a record is waiting on a stalled consumer is dropped. This is acceptable because the prefetcher only offers hints.

Top module: `graph_region_filter`

## Requirements
- R1: After reset `out_valid` is 0 and all four windows are empty, so no event produces a record until a window is programmed.
- R2: An address matches a window when base <= address < end (unsigned compare). An address equal to end does not match, and an address equal to base matches with element number 0.
- R3: `out_index` equals (address - base) >> 3 for 8-byte elements. The three low address bits do not affect it.
- R4: `out_region` codes are: 0 queue, 1 offset array, 2 edge array, 3 seen array.
- R5: When windows overlap, the lowest region code wins: queue, then offset array, then edge array, then seen array.
- R6: An event whose address lies outside every window produces no record.
- R7: `out_src` is 0 for a demand load and 1 for a prefetch fill, and `out_data` is the data word of the chosen event, unchanged.
- R8: When both streams present a matching event in the same cycle, the fill becomes the record and the load is discarded. When only one of the two matches, that one is recorded.
- R9: A window whose base equals its end, or whose base is above its end, never matches.
- R10: While `out_valid` is 1 and `out_ready` is 0, every output field holds its value and newly arriving events are discarded.
- R11: A configuration write uses `cfg_sel[2:1]` as the region code and `cfg_sel[0]` to pick the field (0 base, 1 end). It affects events presented from the cycle after the write.
- R12: A matching event presented while the output slot is free (`out_valid` 0 or `out_ready` 1) appears on the outputs after the next rising clock edge. A cycle with no input event leaves `out_valid` 0 once the slot is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Bound register write strobe |
| cfg_sel | input | 3 | Region code in [2:1], 0 base / 1 end in [0] |
| cfg_wdata | input | AW | Bound value written |
| ld_valid | input | 1 | Demand load event present |
| ld_addr | input | AW | Demand load virtual address |
| ld_data | input | DW | Demand load data word |
| fill_valid | input | 1 | Prefetch fill event present |
| fill_addr | input | AW | Prefetch fill virtual address |
| fill_data | input | DW | Prefetch fill data word |
| out_ready | input | 1 | Consumer accepts the record |
| out_valid | output | 1 | Record present |
| out_region | output | 2 | Region code of the record |
| out_src | output | 1 | 0 demand load, 1 prefetch fill |
| out_index | output | AW-3 | Element number inside the region |
| out_data | output | DW | Data word of the event |

## Verification
Two collisions can land on the same clock edge. The first is a demand load and a prefetch fill arriving together. The bench drives both streams in one cycle with different data words and varies which of the two addresses hits a window, then judges by `out_src` and `out_data` which one survived. The second is a new event arriving while the consumer stalls a waiting record. The bench holds `out_ready` low, presents a second matching event, and checks that the held record is unchanged and that the second event never shows up once the stall ends.

// File: rtl/graph_filter_pkg.sv
package graph_filter_pkg;
   localparam int NUM_REGIONS = 4;
   localparam int REGION_W    = 2;

   typedef enum logic [REGION_W-1:0] {
      RGN_QUEUE  = 2'd0,
      RGN_OFFSET = 2'd1,
      RGN_EDGE   = 2'd2,
      RGN_SEEN   = 2'd3
   } region_e;

   typedef enum logic {
      SRC_DEMAND = 1'b0,
      SRC_FILL   = 1'b1
   } src_e;
endpackage

// File: rtl/gf_bound_regs.sv
module gf_bound_regs
   import graph_filter_pkg::*;
#(
   parameter int AW = 48
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cfg_we,
   input  logic [2:0]                    cfg_sel,
   input  logic [AW-1:0]                 cfg_wdata,
   output logic [NUM_REGIONS-1:0][AW-1:0] base_o,
   output logic [NUM_REGIONS-1:0][AW-1:0] end_o
);
   for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_rgn
      logic sel_hit;
      assign sel_hit = cfg_we && (cfg_sel[2:1] == REGION_W'(r));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            base_o[r] <= '0;
            end_o[r]  <= '0;
         end else if (sel_hit) begin
            if (cfg_sel[0]) end_o[r]  <= cfg_wdata;
            else            base_o[r] <= cfg_wdata;
         end
      end
   end
endmodule

// File: rtl/gf_range_match.sv
module gf_range_match
   import graph_filter_pkg::*;
#(
   parameter int AW         = 48,
   parameter int ELEM_SHIFT = 3
) (
   input  logic [AW-1:0]                  addr_i,
   input  logic [NUM_REGIONS-1:0][AW-1:0] base_i,
   input  logic [NUM_REGIONS-1:0][AW-1:0] end_i,
   output logic                           hit_o,
   output logic [REGION_W-1:0]            region_o,
   output logic [AW-ELEM_SHIFT-1:0]       index_o
);
   logic [NUM_REGIONS-1:0]         in_win;
   logic [NUM_REGIONS-1:0][AW-1:0] offs;

   for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_cmp
      assign in_win[r] = (addr_i >= base_i[r]) && (addr_i < end_i[r]);
      assign offs[r]   = addr_i - base_i[r];
   end

   always_comb begin
      hit_o    = 1'b0;
      region_o = '0;
      index_o  = '0;
      for (int r = NUM_REGIONS - 1; r >= 0; r--) begin
         if (in_win[r]) begin
            hit_o    = 1'b1;
            region_o = REGION_W'(r);
            index_o  = offs[r][AW-1:ELEM_SHIFT];
         end
      end
   end
endmodule

// File: rtl/graph_region_filter.sv
module graph_region_filter
   import graph_filter_pkg::*;
#(
   parameter int AW         = 48,
   parameter int DW         = 64,
   parameter int ELEM_SHIFT = 3,
   parameter bit FILL_FIRST = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_we,
   input  logic [2:0]               cfg_sel,
   input  logic [AW-1:0]            cfg_wdata,
   input  logic                     ld_valid,
   input  logic [AW-1:0]            ld_addr,
   input  logic [DW-1:0]            ld_data,
   input  logic                     fill_valid,
   input  logic [AW-1:0]            fill_addr,
   input  logic [DW-1:0]            fill_data,
   input  logic                     out_ready,
   output logic                     out_valid,
   output logic [1:0]               out_region,
   output logic                     out_src,
   output logic [AW-ELEM_SHIFT-1:0] out_index,
   output logic [DW-1:0]            out_data
);
   localparam int IW     = AW - ELEM_SHIFT;
   localparam int NSRC   = 2;
   localparam int S_LD   = 0;
   localparam int S_FILL = 1;

   if (AW <= ELEM_SHIFT + 1) begin : g_bad_aw
      $error("graph_region_filter: AW too small for ELEM_SHIFT");
   end
   if (DW < 8) begin : g_bad_dw
      $error("graph_region_filter: DW below one byte");
   end

   logic [NUM_REGIONS-1:0][AW-1:0] base_q, end_q;

   gf_bound_regs #(.AW(AW)) u_bounds (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .base_o    (base_q),
      .end_o     (end_q)
   );

   logic [NSRC-1:0][AW-1:0]       s_addr;
   logic [NSRC-1:0]               s_valid;
   logic [NSRC-1:0]               s_hit;
   logic [NSRC-1:0][1:0]          s_region;
   logic [NSRC-1:0][IW-1:0]       s_index;

   assign s_addr[S_LD]    = ld_addr;
   assign s_addr[S_FILL]  = fill_addr;
   assign s_valid[S_LD]   = ld_valid;
   assign s_valid[S_FILL] = fill_valid;

   for (genvar s = 0; s < NSRC; s++) begin : g_src
      gf_range_match #(.AW(AW), .ELEM_SHIFT(ELEM_SHIFT)) u_match (
         .addr_i   (s_addr[s]),
         .base_i   (base_q),
         .end_i    (end_q),
         .hit_o    (s_hit[s]),
         .region_o (s_region[s]),
         .index_o  (s_index[s])
      );
   end

   logic take_ld, take_fill;
   logic ld_ok, fill_ok;
   assign ld_ok   = s_valid[S_LD]   && s_hit[S_LD];
   assign fill_ok = s_valid[S_FILL] && s_hit[S_FILL];

   if (FILL_FIRST) begin : g_fill_first
      assign take_fill = fill_ok;
      assign take_ld   = ld_ok && !fill_ok;
   end else begin : g_load_first
      assign take_ld   = ld_ok;
      assign take_fill = fill_ok && !ld_ok;
   end

   logic slot_free;
   assign slot_free = !out_valid || out_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
      end else if (slot_free) begin
         out_valid <= take_ld || take_fill;
      end
   end

   always_ff @(posedge clk) begin
      if (slot_free && (take_ld || take_fill)) begin
         if (take_fill) begin
            out_region <= s_region[S_FILL];
            out_index  <= s_index[S_FILL];
            out_src    <= SRC_FILL;
            out_data   <= fill_data;
         end else begin
            out_region <= s_region[S_LD];
            out_index  <= s_index[S_LD];
            out_src    <= SRC_DEMAND;
            out_data   <= ld_data;
         end
      end
   end
endmodule

// File: rtl/gf_filter_chk.sv
module gf_filter_chk #(
   parameter int AW = 48,
   parameter int DW = 64,
   parameter int IW = 45
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ld_valid,
   input logic [DW-1:0] ld_data,
   input logic          fill_valid,
   input logic [DW-1:0] fill_data,
   input logic          out_ready,
   input logic          out_valid,
   input logic [1:0]    out_region,
   input logic          out_src,
   input logic [IW-1:0] out_index,
   input logic [DW-1:0] out_data
);
   logic free;
   assign free = !out_valid || out_ready;

   assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_region) && $stable(out_src)
                                    && $stable(out_index) && $stable(out_data)));

   assert_idle_empties_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (free && !ld_valid && !fill_valid) |=> !out_valid);

   assert_load_tag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (free && ld_valid && !fill_valid) |=> (!out_valid || (!out_src && out_data == $past(ld_data))));

   assert_fill_tag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (free && fill_valid && !ld_valid) |=> (!out_valid || (out_src && out_data == $past(fill_data))));

   assert_pair_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (free && fill_valid && ld_valid) |=>
         (!out_valid || out_data == (out_src ? $past(fill_data) : $past(ld_data))));
endmodule

bind graph_region_filter gf_filter_chk #(.AW(AW), .DW(DW), .IW(AW - ELEM_SHIFT)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ld_valid   (ld_valid),
   .ld_data    (ld_data),
   .fill_valid (fill_valid),
   .fill_data  (fill_data),
   .out_ready  (out_ready),
   .out_valid  (out_valid),
   .out_region (out_region),
   .out_src    (out_src),
   .out_index  (out_index),
   .out_data   (out_data)
);

// File: tb/graph_region_filter_tb_top.sv
module graph_region_filter_tb_top;
   localparam int AW = 16;
   localparam int DW = 64;
   localparam int IW = AW - 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [2:0]    cfg_sel = '0;
   logic [AW-1:0] cfg_wdata = '0;
   logic          ld_valid = 1'b0;
   logic [AW-1:0] ld_addr = '0;
   logic [DW-1:0] ld_data = '0;
   logic          fill_valid = 1'b0;
   logic [AW-1:0] fill_addr = '0;
   logic [DW-1:0] fill_data = '0;
   logic          out_ready = 1'b1;
   logic          out_valid;
   logic [1:0]    out_region;
   logic          out_src;
   logic [IW-1:0] out_index;
   logic [DW-1:0] out_data;

   int n_checks = 0;
   int n_fail   = 0;

   logic [AW-1:0] mb [4];
   logic [AW-1:0] me [4];

   always #2.5 clk = ~clk;

   graph_region_filter #(.AW(AW), .DW(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_data(ld_data),
      .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
      .out_ready(out_ready), .out_valid(out_valid), .out_region(out_region),
      .out_src(out_src), .out_index(out_index), .out_data(out_data)
   );

   task automatic check(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic set_bound(input int rgn, input bit is_end, input logic [AW-1:0] v);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = {rgn[1:0], is_end}; cfg_wdata = v;
      if (is_end) me[rgn] = v; else mb[rgn] = v;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic set_region(input int rgn, input logic [AW-1:0] b, input logic [AW-1:0] e);
      set_bound(rgn, 1'b0, b);
      set_bound(rgn, 1'b1, e);
   endtask

   task automatic send(input bit lv, input logic [AW-1:0] la, input logic [DW-1:0] ldd,
                       input bit fv, input logic [AW-1:0] fa, input logic [DW-1:0] fdd);
      @(negedge clk);
      ld_valid = lv; ld_addr = la; ld_data = ldd;
      fill_valid = fv; fill_addr = fa; fill_data = fdd;
      @(negedge clk);
      ld_valid = 1'b0; fill_valid = 1'b0;
   endtask

   function automatic void model(input logic [AW-1:0] a, output bit hit,
                                 output logic [1:0] rg, output logic [IW-1:0] idx);
      logic [AW-1:0] off;
      hit = 1'b0; rg = '0; idx = '0;
      for (int r = 0; r < 4; r++) begin
         if (!hit && a >= mb[r] && a < me[r]) begin
            hit = 1'b1;
            rg  = r[1:0];
            off = a - mb[r];
            idx = IW'(off / 8);
         end
      end
   endfunction

   function automatic logic [DW-1:0] pat(input logic [AW-1:0] a, input bit f);
      return {16'hA5C3, a, ~a, f ? 16'hF111 : 16'h0D0D};
   endfunction

   task automatic sweep(input int lo, input int hi, input bit use_fill, input string tag);
      for (int a = lo; a <= hi; a++) begin
         bit hit;
         logic [1:0] rg;
         logic [IW-1:0] idx;
         logic [AW-1:0] ad = AW'(a);
         model(ad, hit, rg, idx);
         if (use_fill) send(1'b0, '0, '0, 1'b1, ad, pat(ad, 1'b1));
         else          send(1'b1, ad, pat(ad, 1'b0), 1'b0, '0, '0);
         check(out_valid == hit, {tag, " valid"}, 96'(out_valid), 96'(hit));
         if (hit && out_valid)
            check({out_region, out_index, out_src, out_data} == {rg, idx, use_fill, pat(ad, use_fill)},
                  {tag, " record"}, 96'({out_region, out_index, out_src, out_data}),
                  96'({rg, idx, use_fill, pat(ad, use_fill)}));
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++; n_checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      for (int r = 0; r < 4; r++) begin mb[r] = '0; me[r] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state and empty windows
      check(out_valid == 1'b0, "R1 valid after reset", 96'(out_valid), 96'(0));
      send(1'b1, 16'h0000, 64'h1, 1'b1, 16'h0040, 64'h2);
      check(out_valid == 1'b0, "R1 unprogrammed windows", 96'(out_valid), 96'(0));

      // R11 config, R2 R3 R4 R6 R9 sweep on disjoint windows, demand stream
      set_region(0, 16'h0040, 16'h0080);
      set_region(1, 16'h0080, 16'h00C0);
      set_region(2, 16'h0100, 16'h01A0);
      set_region(3, 16'h01A0, 16'h01A0);
      sweep(0, 16'h1FF, 1'b0, "R2_R3_R4_R6_R9_R11 disjoint");

      // R9 inverted window never matches
      set_region(3, 16'h01F0, 16'h01C0);
      sweep(16'h01B8, 16'h01F8, 1'b0, "R9 inverted");

      // R5 overlapping windows, fill stream (R7)
      set_region(0, 16'h0100, 16'h0140);
      set_region(1, 16'h00C0, 16'h0180);
      set_region(2, 16'h0080, 16'h0200);
      set_region(3, 16'h0000, 16'h0300);
      sweep(0, 16'h31F, 1'b1, "R5_R7 overlap");

      // R8: both streams match in one cycle, fill wins
      send(1'b1, 16'h0108, 64'h1111, 1'b1, 16'h0210, 64'h2222);
      check(out_valid && out_src && out_data == 64'h2222 && out_region == 2'd3 && out_index == 13'h42,
            "R8 both match", 96'({out_valid, out_src, out_region, out_index, out_data}),
            96'({1'b1, 1'b1, 2'd3, 13'h42, 64'h2222}));
      // R8: fill misses, load matches, load recorded
      send(1'b1, 16'h0118, 64'h3333, 1'b1, 16'h0400, 64'h4444);
      check(out_valid && !out_src && out_data == 64'h3333 && out_region == 2'd0 && out_index == 13'h3,
            "R8 fill miss", 96'({out_valid, out_src, out_region, out_index, out_data}),
            96'({1'b1, 1'b0, 2'd0, 13'h3, 64'h3333}));
      // R6: both miss
      send(1'b1, 16'h0500, 64'h5, 1'b1, 16'h0600, 64'h6);
      check(out_valid == 1'b0, "R6 both miss", 96'(out_valid), 96'(0));

      // R10: stall holds record and drops new arrivals
      @(negedge clk);
      out_ready = 1'b0;
      ld_valid = 1'b1; ld_addr = 16'h0090; ld_data = 64'hAAAA;
      @(negedge clk);
      ld_addr = 16'h0120; ld_data = 64'hBBBB;
      fill_valid = 1'b1; fill_addr = 16'h0128; fill_data = 64'hCCCC;
      @(negedge clk);
      ld_valid = 1'b0; fill_valid = 1'b0;
      check(out_valid && out_data == 64'hAAAA && out_region == 2'd2 && out_index == 13'h2,
            "R10 held record", 96'({out_valid, out_region, out_index, out_data}),
            96'({1'b1, 2'd2, 13'h2, 64'hAAAA}));
      @(negedge clk);
      check(out_valid && out_data == 64'hAAAA, "R10 still held",
            96'({out_valid, out_data}), 96'({1'b1, 64'hAAAA}));
      out_ready = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0, "R10 dropped during stall", 96'(out_valid), 96'(0));

      // R12: back-to-back events each appear one edge later
      @(negedge clk);
      ld_valid = 1'b1; ld_addr = 16'h0100; ld_data = 64'h77;
      @(negedge clk);
      check(out_valid && out_data == 64'h77 && out_index == 13'h0, "R12 first",
            96'({out_valid, out_index, out_data}), 96'({1'b1, 13'h0, 64'h77}));
      ld_addr = 16'h013F; ld_data = 64'h88;
      @(negedge clk);
      ld_valid = 1'b0;
      check(out_valid && out_data == 64'h88 && out_index == 13'h7 && out_region == 2'd0, "R12 second",
            96'({out_valid, out_region, out_index, out_data}), 96'({1'b1, 2'd0, 13'h7, 64'h88}));
      @(negedge clk);
      check(out_valid == 1'b0, "R12 idle", 96'(out_valid), 96'(0));

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule